// File: doc/BRIEF.md
# Peripheral interrupt sense and latch block

This block gives one peripheral eight interrupt inputs and a single combined interrupt output. Each input has its own detection setup. It can watch for a level, with the active level chosen, or for an edge. In edge mode, rising and falling edges are enabled separately, so one line can catch both. Qualifying events are held in a latched status bitmap. The bitmap is gated by an enable bitmap, and the gated bits are ORed onto the output.

Software reaches the block through a synchronous byte-wide register port with an 8-bit address. A write takes effect on the clock edge that samples it. A read returns its data in the cycle after the request. The enable bitmap and the latched bitmap have no direct write. Software changes them only through write-one-to-set and write-one-to-clear registers, so a zero bit in the written data never disturbs another line. The raw inputs are assumed to be synchronous to the block clock already.

Top module: `irq_sense_latch`

## Requirements
- R1: After reset, every register reads zero and the interrupt output is low.
- R2: Line n owns bit n of every register. The detect-type register sits at 0x11, where 1 means edge and 0 means level. The high-polarity register sits at 0x12 and the low-polarity register at 0x13. All three read back the value last written to them.
- R3: Writes on consecutive cycles to 0x11, 0x12 and 0x13 each take effect, so the three can be loaded as a burst with the address stepping by one.
- R4: An edge-mode line with its high-polarity bit set latches when its input is 1 and was 0 in the previous cycle.
- R5: An edge-mode line with its low-polarity bit set latches when its input is 0 and was 1 in the previous cycle. With both polarity bits set, the line latches on either edge.
- R6: A level-mode line latches in every cycle in which its input is at the active level. The active level is 1 if the high-polarity bit is set and 0 if the low-polarity bit is set.
- R7: A line latches nothing for an edge or level whose matching polarity bit is clear.
- R8: Writing ones to 0x15 sets those enable bits. Writing ones to 0x16 clears them. Zero bits in either write leave the enable state unchanged.
- R9: Writing ones to 0x18's companion register 0x14 clears those latched bits. If a qualifying event hits the same bit in the same cycle, the bit stays set.
- R10: Latched bits are set even while their line is disabled. The output is high exactly when some line is both latched and enabled.
- R11: A read of 0x10 returns each line's input, inverted only for lines whose low-polarity bit is set and whose high-polarity bit is clear.
- R12: Read data appears in the cycle after the read request and holds until the next read. Address 0x18 returns the latched bitmap. Addresses 0x14, 0x15, 0x16 and all unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| rd_en | input | 1 | Read strobe for the register port |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data, one bit per line |
| rdata | output | 8 | Registered read data |
| irq_in | input | 8 | Raw interrupt inputs, already synchronous |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a latched-clear write that lands in the same cycle as a fresh event on the same bit. The bench reaches it in two ways. First, it holds a level-mode line at its active level while clearing every latched bit. Second, it runs a long stretch where writes to every register interleave with a changing input word. In that stretch, clears meet edges and levels in all combinations. A behavioural model in the bench follows each cycle, so any cycle where the set-wins rule or the edge history differs shows up on the output or on the next read.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

    localparam int ADDR_W = 8;

    typedef enum logic [3:0] {
        RS_NONE,
        RS_LIVE,
        RS_KIND,
        RS_POLH,
        RS_POLL,
        RS_LCLR,
        RS_ENSET,
        RS_ENCLR,
        RS_LSTS
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            8'h10:   return RS_LIVE;
            8'h11:   return RS_KIND;
            8'h12:   return RS_POLH;
            8'h13:   return RS_POLL;
            8'h14:   return RS_LCLR;
            8'h15:   return RS_ENSET;
            8'h16:   return RS_ENCLR;
            8'h18:   return RS_LSTS;
            default: return RS_NONE;
        endcase
    endfunction

    // Polarity-adjusted live view of one line.
    function automatic logic qualify(input logic lvl, input logic ph, input logic pl);
        return lvl ^ (pl & ~ph);
    endfunction

endpackage

// File: rtl/isl_regs.sv
module isl_regs
    import irq_sense_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  reg_sel_e             sel,
    input  logic [NUM_LINES-1:0] wdata,
    output logic [NUM_LINES-1:0] kind,
    output logic [NUM_LINES-1:0] pol_hi,
    output logic [NUM_LINES-1:0] pol_lo,
    output logic [NUM_LINES-1:0] enable,
    output logic [NUM_LINES-1:0] lat_clr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            kind   <= '0;
            pol_hi <= '0;
            pol_lo <= '0;
            enable <= '0;
        end else if (wr_en) begin
            case (sel)
                RS_KIND:  kind   <= wdata;
                RS_POLH:  pol_hi <= wdata;
                RS_POLL:  pol_lo <= wdata;
                RS_ENSET: enable <= enable | wdata;
                RS_ENCLR: enable <= enable & ~wdata;
                default:  ;
            endcase
        end
    end

    assign lat_clr = (wr_en && sel == RS_LCLR) ? wdata : '0;

    // R8: set bits appear after an enable-set write
    a_r8_enable_set: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == RS_ENSET) |=> ((enable & $past(wdata)) == $past(wdata)));

    // R8: cleared bits are gone after an enable-clear write
    a_r8_enable_clr: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == RS_ENCLR) |=> ((enable & $past(wdata)) == '0));

    // R8: enable holds without a set or clear write
    a_r8_enable_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (sel == RS_ENSET || sel == RS_ENCLR)) |=> $stable(enable));

    // R2: configuration holds without a write to it
    a_r2_kind_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel == RS_KIND) |=> $stable(kind));

endmodule

// File: rtl/isl_line.sv
module isl_line
    import irq_sense_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_lvl,
    input  logic kind,
    input  logic pol_hi,
    input  logic pol_lo,
    input  logic clr,
    output logic event_hit,
    output logic latched,
    output logic live
);

    logic prev_lvl;
    logic rise, fall, lvl_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lvl <= 1'b0;
            latched  <= 1'b0;
        end else begin
            prev_lvl <= in_lvl;
            latched  <= (latched & ~clr) | event_hit;
        end
    end

    always_comb begin
        rise    = pol_hi & in_lvl & ~prev_lvl;
        fall    = pol_lo & ~in_lvl & prev_lvl;
        lvl_hit = (pol_hi & in_lvl) | (pol_lo & ~in_lvl);
        event_hit = kind ? (rise | fall) : lvl_hit;
    end

    assign live = qualify(in_lvl, pol_hi, pol_lo);

    // R9: an event always leaves the bit set, even against a clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        event_hit |=> latched);

    // R9: a clear with no event empties the bit
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !event_hit) |=> !latched);

    // R7: no polarity selected means no event
    a_r7_no_polarity: assert property (@(posedge clk) disable iff (rst)
        (!pol_hi && !pol_lo) |-> !event_hit);

    // R4: edge mode with a steady input raises nothing new
    a_r4_edge_steady: assert property (@(posedge clk) disable iff (rst)
        (kind && in_lvl == prev_lvl && !latched) |=> !latched);

endmodule

// File: rtl/irq_sense_latch.sv
module irq_sense_latch
    import irq_sense_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_LINES-1:0] wdata,
    output logic [NUM_LINES-1:0] rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic                 irq_out
);

    reg_sel_e             sel;
    logic [NUM_LINES-1:0] kind, pol_hi, pol_lo, enable, lat_clr;
    logic [NUM_LINES-1:0] event_vec, lat_vec, live_vec;
    logic [NUM_LINES-1:0] rd_mux;

    assign sel = decode_addr(addr);

    isl_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .sel     (sel),
        .wdata   (wdata),
        .kind    (kind),
        .pol_hi  (pol_hi),
        .pol_lo  (pol_lo),
        .enable  (enable),
        .lat_clr (lat_clr)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        isl_line u_line (
            .clk       (clk),
            .rst       (rst),
            .in_lvl    (irq_in[n]),
            .kind      (kind[n]),
            .pol_hi    (pol_hi[n]),
            .pol_lo    (pol_lo[n]),
            .clr       (lat_clr[n]),
            .event_hit (event_vec[n]),
            .latched   (lat_vec[n]),
            .live      (live_vec[n])
        );
    end

    always_comb begin
        case (sel)
            RS_LIVE: rd_mux = live_vec;
            RS_KIND: rd_mux = kind;
            RS_POLH: rd_mux = pol_hi;
            RS_POLL: rd_mux = pol_lo;
            RS_LSTS: rd_mux = lat_vec;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assign irq_out = |(lat_vec & enable);

    // R12: read data holds between reads
    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    // R10: nothing enabled means no request
    a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
        (enable == '0) |-> !irq_out);

    // R10: an enabled event raises the request in the next cycle
    a_r10_raise: assert property (@(posedge clk) disable iff (rst)
        ((event_vec & enable) != '0 && !(wr_en && sel == RS_ENCLR)) |=> irq_out);

endmodule

// File: tb/irq_sense_latch_bench.sv
module irq_sense_latch_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] irq_in = '0;
    logic [7:0] rdata;
    logic       irq_out;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    irq_sense_latch u_irq_sense_latch (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .irq_out(irq_out)
    );

    // behavioural reference
    logic [7:0] m_kind, m_ph, m_pl, m_en, m_lat, m_prev, m_rd;
    logic [7:0] m_evt;

    function automatic logic [7:0] m_read(input logic [7:0] a);
        logic [7:0] r;
        r = 8'h00;
        if (a == 8'h10) begin
            for (int i = 0; i < 8; i++)
                r[i] = (m_pl[i] && !m_ph[i]) ? !irq_in[i] : irq_in[i];
        end else if (a == 8'h11) r = m_kind;
        else if (a == 8'h12) r = m_ph;
        else if (a == 8'h13) r = m_pl;
        else if (a == 8'h18) r = m_lat;
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_kind = 0; m_ph = 0; m_pl = 0; m_en = 0; m_lat = 0; m_prev = 0; m_rd = 0;
        end else begin
            if (rd_en) m_rd = m_read(addr);
            m_evt = 0;
            for (int i = 0; i < 8; i++) begin
                if (m_kind[i]) begin
                    if (m_ph[i] && irq_in[i] && !m_prev[i]) m_evt[i] = 1;
                    if (m_pl[i] && !irq_in[i] && m_prev[i]) m_evt[i] = 1;
                end else begin
                    if (m_ph[i] && irq_in[i]) m_evt[i] = 1;
                    if (m_pl[i] && !irq_in[i]) m_evt[i] = 1;
                end
            end
            if (wr_en && addr == 8'h14) m_lat = m_lat & ~wdata;
            m_lat = m_lat | m_evt;
            if (wr_en) begin
                case (addr)
                    8'h11: m_kind = wdata;
                    8'h12: m_ph = wdata;
                    8'h13: m_pl = wdata;
                    8'h15: m_en = m_en | wdata;
                    8'h16: m_en = m_en & ~wdata;
                    default: ;
                endcase
            end
            m_prev = irq_in;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R10 irq_out vs model", {7'b0, irq_out}, {7'b0, |(m_lat & m_en)});
            check("R12 rdata vs model", rdata, m_rd);
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1; addr = a; wdata = d;
        step();
        wr_en = 0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
        rd_en = 1; addr = a;
        step();
        rd_en = 0;
        check(tag, rdata, exp);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) step();
        rst = 0;
        step();
        // R1
        check("R1 irq_out after reset", {7'b0, irq_out}, 8'h00);
        rd_chk(8'h11, 8'h00, "R1 type reset");
        rd_chk(8'h18, 8'h00, "R1 latched reset");
        // R3 burst: line0 rise, 1 fall, 2 both, 3 edge none, 4 level hi, 5 level lo
        wr_en = 1; addr = 8'h11; wdata = 8'h0F; step();
        addr = 8'h12; wdata = 8'h15; step();
        addr = 8'h13; wdata = 8'h26; step();
        wr_en = 0;
        rd_chk(8'h11, 8'h0F, "R2 R3 type readback");
        rd_chk(8'h12, 8'h15, "R2 R3 polarity-high readback");
        rd_chk(8'h13, 8'h26, "R2 R3 polarity-low readback");
        rd_chk(8'h10, 8'h22, "R11 live status inputs low");
        rd_chk(8'h18, 8'h20, "R6 level-low latched");
        wr(8'h14, 8'hFF);
        rd_chk(8'h18, 8'h20, "R9 set wins over clear");
        irq_in = 8'hFF;
        step(); step();
        rd_chk(8'h18, 8'h35, "R4 R6 R7 rising pattern");
        rd_chk(8'h10, 8'hDD, "R11 live status inputs high");
        check("R10 latched but disabled", {7'b0, irq_out}, 8'h00);
        wr(8'h15, 8'h01);
        check("R8 R10 enable set raises", {7'b0, irq_out}, 8'h01);
        wr(8'h16, 8'h00);
        check("R8 zero clear no effect", {7'b0, irq_out}, 8'h01);
        wr(8'h16, 8'h01);
        check("R8 enable clear drops", {7'b0, irq_out}, 8'h00);
        wr(8'h14, 8'h35);
        rd_chk(8'h18, 8'h10, "R9 R6 clear with level held");
        irq_in = 8'h00;
        step(); step();
        rd_chk(8'h18, 8'h36, "R5 falling pattern");
        rd_chk(8'h17, 8'h00, "R12 unmapped reads zero");
        rd_chk(8'h15, 8'h00, "R12 write-only reads zero");
        wr(8'h15, 8'hC0);
        check("R10 enabled lines not latched", {7'b0, irq_out}, 8'h00);
        wr(8'h15, 8'h02);
        check("R10 enabled latched line", {7'b0, irq_out}, 8'h01);
        // mixed traffic checked by the model
        for (int k = 0; k < 3000; k++) begin
            logic [2:0] pick;
            pick = 3'($urandom_range(0, 7));
            irq_in = 8'($urandom);
            wr_en = ($urandom_range(0, 2) == 0);
            rd_en = ($urandom_range(0, 1) == 0);
            case (pick)
                3'd0: addr = 8'h10;
                3'd1: addr = 8'h11;
                3'd2: addr = 8'h12;
                3'd3: addr = 8'h13;
                3'd4: addr = 8'h14;
                3'd5: addr = 8'h15;
                3'd6: addr = 8'h16;
                default: addr = 8'h18;
            endcase
            wdata = 8'($urandom);
            step();
        end
        wr_en = 0; rd_en = 0;
        step();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule